// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block carries byte-wide data between two ports, A and B, and keeps one storage register for each direction of travel. Each port is split into an input bus, an output bus and an output-enable bit, so no tri-state pad is involved. Each direction has its own capture strobe and its own source select. The select picks either the live value on the opposite port or the byte held in that direction's register. The default build holds two fully independent 8-bit sections. Each section has its own enable, direction, two capture strobes and two source selects.

Everything runs on one system clock `clk`. A capture strobe counts as a "clock" for its register when it rises, and the block finds that rise by comparing the strobe with its value on the previous `clk` edge.

Each section has a three-state drive controller:
- `MODE_ISOLATE`: neither port is driven.
- `MODE_DRIVE_B`: B is driven from the A side.
- `MODE_DRIVE_A`: A is driven from the B side.

The controller moves as follows:
- From `MODE_ISOLATE`, it takes whatever mode the controls ask for on the next edge.
- From either drive state, it stays put while the same mode is still asked for.
- From either drive state, any other request (isolation, or the opposite direction) sends it to `MODE_ISOLATE` for one cycle first. This is a break-before-make turnaround.

The registers keep loading in every state, including isolation.

Top module: `regbus_xcvr`

## Requirements
- R1: After the synchronous active-high reset, both storage registers of every section hold zero, every section is in `MODE_ISOLATE`, and all output enables and output buses are zero.
- R2: The A-to-B register of a section loads that section's A input on the first `clk` edge at which its `cap_ab` bit is high after being low at the previous edge. Holding `cap_ab` high does not reload it.
- R3: The B-to-A register loads the B input under the same rule, using `cap_ba`.
- R4: When a section's `oe_n` is 1 at a `clk` edge, both of that section's output enables are 0 after that edge.
- R5: From `MODE_ISOLATE`, the edge that samples `oe_n`=0 does the following: with `dir`=1 the section enters `MODE_DRIVE_B` (`b_oe`=1); with `dir`=0 it enters `MODE_DRIVE_A` (`a_oe`=1).
- R6: When the direction request changes while a port is driven, the section spends exactly one cycle with both enables at 0 before it drives the other port.
- R7: With `sel_ab`=0, a driven B output equals the section's live A input in the same cycle. With `sel_ba`=0, a driven A output equals the live B input.
- R8: With `sel_ab`=1 (or `sel_ba`=1), the driven output shows the A-to-B (or B-to-A) register. A new capture becomes visible in the cycle right after the loading edge.
- R9: Both registers load in isolation and while either port is driven, and either one or both may load in the same cycle.
- R10: A section never asserts `a_oe` and `b_oe` together.
- R11: Sections are independent. Controls and data of one section never change another section's outputs or registers.
- R12: An output bus whose enable is 0 is held at all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | SECTIONS | Active-low output enable, one bit per section |
| dir | input | SECTIONS | 1 drives B, 0 drives A |
| cap_ab | input | SECTIONS | Capture strobe of the A-to-B register (rising) |
| cap_ba | input | SECTIONS | Capture strobe of the B-to-A register (rising) |
| sel_ab | input | SECTIONS | B output source: 0 live A, 1 stored |
| sel_ba | input | SECTIONS | A output source: 0 live B, 1 stored |
| a_in | input | SECTIONS*WIDTH | A port input bus |
| a_out | output | SECTIONS*WIDTH | A port output bus |
| a_oe | output | SECTIONS | A port output enable |
| b_in | input | SECTIONS*WIDTH | B port input bus |
| b_out | output | SECTIONS*WIDTH | B port output bus |
| b_oe | output | SECTIONS | B port output enable |

## Verification
The live path (R7, R12) is combinational, so its checks look one time step after the bench changes a data or select input, with no clock edge in between. Enable changes (R4, R5, R6) and register loads (R2, R3, R8, R9) take effect at the first `clk` rising edge that samples the stimulus. The bench therefore drives inputs on the falling edge and checks registered results at the next falling edge, exactly one rising edge later. The turnaround check samples at two consecutive falling edges, to see the single isolation cycle and then the new port.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_B = 2'd1,
        MODE_DRIVE_A = 2'd2
    } xcvr_mode_e;

    // Mode asked for by the raw controls, before turnaround rules apply.
    function automatic xcvr_mode_e requested_mode(input logic oe_n, input logic dir);
        if (oe_n)
            return MODE_ISOLATE;
        else if (dir)
            return MODE_DRIVE_B;
        else
            return MODE_DRIVE_A;
    endfunction

endpackage

// File: rtl/regbus_xcvr_ctrl.sv
module regbus_xcvr_ctrl
    import regbus_xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic oe_n,
    input  logic dir,
    output logic drive_a,
    output logic drive_b
);

    xcvr_mode_e state_q;
    xcvr_mode_e state_d;
    xcvr_mode_e req;

    always_comb begin
        req = requested_mode(oe_n, dir);
        state_d = MODE_ISOLATE;
        unique case (state_q)
            MODE_ISOLATE: state_d = req;
            MODE_DRIVE_B: state_d = (req == MODE_DRIVE_B) ? MODE_DRIVE_B : MODE_ISOLATE;
            MODE_DRIVE_A: state_d = (req == MODE_DRIVE_A) ? MODE_DRIVE_A : MODE_ISOLATE;
            default:      state_d = MODE_ISOLATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= MODE_ISOLATE;
        else
            state_q <= state_d;
    end

    always_comb begin
        drive_a = 1'b0;
        drive_b = 1'b0;
        unique case (state_q)
            MODE_ISOLATE: ;
            MODE_DRIVE_B: drive_b = 1'b1;
            MODE_DRIVE_A: drive_a = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/regbus_xcvr_store.sv
module regbus_xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic cap_prev_q;
    logic cap_rise;

    assign cap_rise = cap & ~cap_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_prev_q <= 1'b0;
            q          <= '0;
        end else begin
            cap_prev_q <= cap;
            if (cap_rise)
                q <= d;
        end
    end

endmodule

// File: rtl/regbus_xcvr_section.sv
module regbus_xcvr_section #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out,
    output logic             a_oe,
    output logic             b_oe
);

    logic             drive_a;
    logic             drive_b;
    logic [WIDTH-1:0] stored_ab;
    logic [WIDTH-1:0] stored_ba;
    logic [WIDTH-1:0] src_to_b;
    logic [WIDTH-1:0] src_to_a;

    regbus_xcvr_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .oe_n    (oe_n),
        .dir     (dir),
        .drive_a (drive_a),
        .drive_b (drive_b)
    );

    regbus_xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
        .clk (clk),
        .rst (rst),
        .cap (cap_ab),
        .d   (a_in),
        .q   (stored_ab)
    );

    regbus_xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
        .clk (clk),
        .rst (rst),
        .cap (cap_ba),
        .d   (b_in),
        .q   (stored_ba)
    );

    always_comb begin
        src_to_b = sel_ab ? stored_ab : a_in;
        src_to_a = sel_ba ? stored_ba : b_in;
        b_out    = drive_b ? src_to_b : '0;
        a_out    = drive_a ? src_to_a : '0;
        b_oe     = drive_b;
        a_oe     = drive_a;
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int SECTIONS = 2,
    parameter int WIDTH    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SECTIONS-1:0]       oe_n,
    input  logic [SECTIONS-1:0]       dir,
    input  logic [SECTIONS-1:0]       cap_ab,
    input  logic [SECTIONS-1:0]       cap_ba,
    input  logic [SECTIONS-1:0]       sel_ab,
    input  logic [SECTIONS-1:0]       sel_ba,
    input  logic [SECTIONS*WIDTH-1:0] a_in,
    output logic [SECTIONS*WIDTH-1:0] a_out,
    output logic [SECTIONS-1:0]       a_oe,
    input  logic [SECTIONS*WIDTH-1:0] b_in,
    output logic [SECTIONS*WIDTH-1:0] b_out,
    output logic [SECTIONS-1:0]       b_oe
);

    localparam int BUS_W = SECTIONS * WIDTH;

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        localparam int LO = s * WIDTH;
        regbus_xcvr_section #(.WIDTH(WIDTH)) u_sec (
            .clk    (clk),
            .rst    (rst),
            .oe_n   (oe_n[s]),
            .dir    (dir[s]),
            .cap_ab (cap_ab[s]),
            .cap_ba (cap_ba[s]),
            .sel_ab (sel_ab[s]),
            .sel_ba (sel_ba[s]),
            .a_in   (a_in[LO +: WIDTH]),
            .b_in   (b_in[LO +: WIDTH]),
            .a_out  (a_out[LO +: WIDTH]),
            .b_out  (b_out[LO +: WIDTH]),
            .a_oe   (a_oe[s]),
            .b_oe   (b_oe[s])
        );
    end

    initial begin
        if (BUS_W != SECTIONS * WIDTH) $error("bus width mismatch");
    end

endmodule

// File: rtl/regbus_xcvr_checker.sv
module regbus_xcvr_checker #(
    parameter int SECTIONS = 2,
    parameter int WIDTH    = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [SECTIONS-1:0]       oe_n,
    input logic [SECTIONS-1:0]       dir,
    input logic [SECTIONS-1:0]       sel_ab,
    input logic [SECTIONS-1:0]       sel_ba,
    input logic [SECTIONS*WIDTH-1:0] a_in,
    input logic [SECTIONS*WIDTH-1:0] b_in,
    input logic [SECTIONS*WIDTH-1:0] a_out,
    input logic [SECTIONS*WIDTH-1:0] b_out,
    input logic [SECTIONS-1:0]       a_oe,
    input logic [SECTIONS-1:0]       b_oe
);

    for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
        localparam int LO = s * WIDTH;

        a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
            !(a_oe[s] && b_oe[s]));

        a_r4_isolate: assert property (@(posedge clk) disable iff (rst)
            oe_n[s] |=> (!a_oe[s] && !b_oe[s]));

        a_r5_enter_b: assert property (@(posedge clk) disable iff (rst)
            (!a_oe[s] && !b_oe[s] && !oe_n[s] && dir[s]) |=> b_oe[s]);

        a_r6_turn_a: assert property (@(posedge clk) disable iff (rst)
            a_oe[s] |=> !b_oe[s]);

        a_r6_turn_b: assert property (@(posedge clk) disable iff (rst)
            b_oe[s] |=> !a_oe[s]);

        a_r7_live_b: assert property (@(posedge clk) disable iff (rst)
            (b_oe[s] && !sel_ab[s]) |-> (b_out[LO +: WIDTH] == a_in[LO +: WIDTH]));

        a_r7_live_a: assert property (@(posedge clk) disable iff (rst)
            (a_oe[s] && !sel_ba[s]) |-> (a_out[LO +: WIDTH] == b_in[LO +: WIDTH]));

        a_r12_quiet: assert property (@(posedge clk) disable iff (rst)
            (!a_oe[s] |-> a_out[LO +: WIDTH] == '0) and (!b_oe[s] |-> b_out[LO +: WIDTH] == '0));
    end

endmodule

bind regbus_xcvr regbus_xcvr_checker #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .b_out  (b_out),
    .a_oe   (a_oe),
    .b_oe   (b_oe)
);

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;

    localparam int CLK_PERIOD = 10;
    localparam int S = 2;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [S-1:0]   oe_n = '1, dir = '0, cap_ab = '0, cap_ba = '0, sel_ab = '0, sel_ba = '0;
    logic [S*W-1:0] a_in = '0, b_in = '0;
    logic [S*W-1:0] a_out, b_out;
    logic [S-1:0]   a_oe, b_oe;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbus_xcvr #(.SECTIONS(S), .WIDTH(W)) uut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] ao(input int s); return a_out[s*W +: W]; endfunction
    function automatic logic [W-1:0] bo(input int s); return b_out[s*W +: W]; endfunction

    task automatic set_ctl(input int s, input logic n, input logic d, input logic sab, input logic sba);
        oe_n[s] = n; dir[s] = d; sel_ab[s] = sab; sel_ba[s] = sba;
    endtask

    // Pulse both capture strobes of section s with the given data; one rising clk edge loads.
    task automatic load(input int s, input logic [W-1:0] va, input logic [W-1:0] vb,
                        input logic do_ab, input logic do_ba);
        a_in[s*W +: W] = va; b_in[s*W +: W] = vb;
        cap_ab[s] = do_ab; cap_ba[s] = do_ba;
        tick();
        cap_ab[s] = 1'b0; cap_ba[s] = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state visible at the ports
        chk("R1 a_oe", a_oe, 0); chk("R1 b_oe", b_oe, 0);
        chk("R1 a_out", a_out, 0); chk("R1 b_out", b_out, 0);
        // R1: registers zero -> drive B with stored source in both sections
        set_ctl(0, 0, 1, 1, 1); set_ctl(1, 0, 0, 1, 1);
        a_in = 16'hA5A5; b_in = 16'h5A5A;
        tick();
        chk("R1 stored_ab s0", bo(0), 0); chk("R1 stored_ba s1", ao(1), 0);
        chk("R5 b_oe s0", b_oe[0], 1); chk("R5 a_oe s1", a_oe[1], 1);

        // Sweep over every control combination of each section
        for (int s = 0; s < S; s++) begin
            for (int c = 0; c < 16; c++) begin
                logic [W-1:0] p1, p2, p3, p4;
                logic n, d, sab, sba, drb, dra;
                logic [W-1:0] eb, ea;
                p1 = W'(c * 17 + 3 + s * 5); p2 = W'(c * 29 + 11);
                p3 = W'(c * 13 + 200); p4 = W'(~(c * 7) + s);
                set_ctl(0, 1, 0, 0, 0); set_ctl(1, 1, 0, 0, 0);
                tick(); tick();
                load(s, p1, p2, 1, 1);                    // R9: load in isolation
                n = c[3]; d = c[2]; sab = c[1]; sba = c[0];
                set_ctl(s, n, d, sab, sba);
                a_in[s*W +: W] = p3; b_in[s*W +: W] = p4;
                tick();
                drb = !n && d; dra = !n && !d;
                eb = drb ? (sab ? p1 : p3) : '0;
                ea = dra ? (sba ? p2 : p4) : '0;
                chk(n ? "R4 b_oe" : "R5 b_oe", b_oe[s], drb);
                chk(n ? "R4 a_oe" : "R5 a_oe", a_oe[s], dra);
                chk(sab ? "R8 b_out" : "R7 b_out", bo(s), eb);
                chk(sba ? "R8 a_out" : "R7 a_out", ao(s), ea);
                chk("R10 exclusive", a_oe[s] & b_oe[s], 0);
                chk("R11 other oe", {a_oe[1-s], b_oe[1-s]}, 0);
                chk("R11 other out", {ao(1-s), bo(1-s)}, 0);
            end
        end

        // R7: live path follows input combinationally
        set_ctl(0, 0, 1, 0, 0); set_ctl(1, 1, 0, 0, 0);
        tick(); tick();
        a_in[7:0] = 8'h3C; #1;
        chk("R7 live same cycle", bo(0), 8'h3C);
        a_in[7:0] = 8'hC3; #1;
        chk("R7 live same cycle 2", bo(0), 8'hC3);
        chk("R12 idle a_out", ao(0), 0);

        // R2 + R8: held strobe does not reload; new capture visible right after edge
        sel_ab[0] = 1'b1;
        load(0, 8'h11, 8'h00, 1, 0);
        chk("R2 loaded", bo(0), 8'h11);
        a_in[7:0] = 8'h22; cap_ab[0] = 1'b1; #1;
        chk("R8 before edge", bo(0), 8'h11);
        tick();
        chk("R8 after edge", bo(0), 8'h22);
        a_in[7:0] = 8'h33;
        tick(); tick();
        chk("R2 held no reload", bo(0), 8'h22);
        cap_ab[0] = 1'b0;
        tick();
        chk("R2 fall no load", bo(0), 8'h22);

        // R9: load B-to-A register while B is being driven
        load(0, 8'h00, 8'h77, 0, 1);
        chk("R9 ab kept", bo(0), 8'h22);

        // R6: turnaround B -> A passes one isolation cycle
        dir[0] = 1'b0; sel_ba[0] = 1'b1;
        tick();
        chk("R6 gap a_oe", a_oe[0], 0); chk("R6 gap b_oe", b_oe[0], 0);
        tick();
        chk("R6 a_oe", a_oe[0], 1); chk("R9 ba stored", ao(0), 8'h77);
        // R3: held B-to-A strobe loads once
        b_in[7:0] = 8'h44; cap_ba[0] = 1'b1;
        tick();
        chk("R3 loaded", ao(0), 8'h44);
        b_in[7:0] = 8'h55;
        tick();
        chk("R3 held no reload", ao(0), 8'h44);
        cap_ba[0] = 1'b0;
        // R6: turnaround A -> B
        dir[0] = 1'b1;
        tick();
        chk("R6 gap2", {a_oe[0], b_oe[0]}, 0);
        tick();
        chk("R6 b_oe", b_oe[0], 1);
        // R4: disable while driving
        oe_n[0] = 1'b1;
        tick();
        chk("R4 off", {a_oe[0], b_oe[0]}, 0);
        chk("R12 off out", bo(0), 0);

        // R11: section 1 registers untouched by section 0 loads (last set in sweep)
        set_ctl(1, 0, 1, 1, 0);
        tick();
        chk("R11 s1 stored", bo(1), W'(15 * 17 + 3 + 5));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule